// File: doc/BRIEF.md
# Debug Serial Port with Parity and Channel Routing

This block is a register-mapped asynchronous serial port for console and debug traffic. It sends and receives 8-bit characters framed by one start bit (low) and one stop bit (high), with an optional parity bit. The transmitter and receiver each have their own enable and reset commands. A 16-bit divisor sets the baud rate, and the shifters run on a tick at sixteen times the bit rate.

Software works the port through a 32-bit register bus with a one-cycle write strobe and a one-cycle read strobe. It issues commands and picks one of five parity types and one of four line routings. Three registers control the interrupt mask: one sets mask bits, one clears them and one reads them back. The status word shows the ready, empty and latched error flags. One registered interrupt line is high while any status bit that is unmasked is set.

Top module: `dbg_serial_port`

## Requirements
- R1: Register offsets are 0x00 command, 0x04 mode, 0x08 mask-set, 0x0C mask-clear, 0x10 mask read, 0x14 status, 0x18 received character, 0x1C character to send, 0x20 divisor (bits 15:0). After reset, status reads 0x202, and mask, mode, divisor and the received character read 0. Both directions are disabled, and irq is 0 and txd is 1.
- R2: Every bit lasts 16 ticks, and a tick occurs every divisor clocks. The start bit may be up to divisor-1 clocks short. Data goes out LSB first. A divisor of 0 stops the tick and keeps a waiting character from starting.
- R3: Mode bits 11:9 select parity: 0 even, 1 odd, 2 parity bit always 0, 3 parity bit always 1, 4 no parity bit. The transmitter sends the selected bit and the receiver checks it.
- R4: The receiver confirms a start bit at its midpoint and samples each following bit at its midpoint. A completed character sets status bit 0. A read of offset 0x18 returns the character and clears bit 0. Read data is valid on the cycle after the read strobe.
- R5: Writing a character clears status bit 1 (transmitter ready). Bit 1 sets again when the character moves to the shifter. Status bit 9 (transmitter empty) is 1 only while both the holding register and the shifter are idle, and txd then stays high in normal routing.
- R6: If a character completes while status bit 0 is still set, status bit 5 (overrun) latches and the new character replaces the old one.
- R7: A stop bit sampled low latches status bit 6. A parity mismatch latches status bit 7. Writing command bit 8 clears bits 7:5.
- R8: Writing 1s to the mask-set register sets mask bits. Writing 1s to the mask-clear register clears them. Only bits 0, 1, 5, 6, 7 and 9 can hold a mask bit.
- R9: irq equals the OR of (status AND mask), registered one clock after the status change.
- R10: Mode bits 15:14 select routing. 0 is normal. 1 is echo: rxd feeds the receiver and is copied to txd. 2 is local loop: the transmitter feeds the receiver and txd is held high. 3 is remote loop: rxd is copied to txd and the receiver sees an idle line. Copies to txd are delayed one clock.
- R11: Command bits 4 and 5 enable and disable the receiver. Bits 6 and 7 do the same for the transmitter, and a disable wins if both bits are written together. A disabled receiver completes no character. A disabled transmitter keeps its waiting character and holds its line high.
- R12: Command bit 2 resets the receiver and clears status bit 0. Command bit 3 resets the transmitter, drops any waiting character and returns status bits 1 and 9 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (6) | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| irq | output | 1 | Interrupt request |
| rxd | input | 1 | Serial input line |
| txd | output | 1 | Serial output line (registered) |

## Verification
A register write takes effect at the clock edge that samples the strobe. A status read issued in the next cycle therefore already shows the change, and the bench reads status only after each write task has returned. Read data arrives one clock after the strobe, so the bench samples rdata on the falling edge that follows that clock. irq lags status by one more clock, so the bench waits one extra falling edge before it checks irq. Serial timing is handled by counting clocks from the falling edge of the start bit and sampling in the middle of each 16-tick bit. Received characters are collected by polling status bit 0, with a bounded poll count, instead of by predicting the exact completion cycle.

// File: rtl/sp_pkg.sv
package sp_pkg;

  // register byte offsets
  localparam int OFF_CMD   = 'h00;
  localparam int OFF_MODE  = 'h04;
  localparam int OFF_MSET  = 'h08;
  localparam int OFF_MCLR  = 'h0C;
  localparam int OFF_MASK  = 'h10;
  localparam int OFF_STAT  = 'h14;
  localparam int OFF_RXCH  = 'h18;
  localparam int OFF_TXCH  = 'h1C;
  localparam int OFF_BAUD  = 'h20;

  // command strobe bits
  localparam int CMD_RX_RST = 2;
  localparam int CMD_TX_RST = 3;
  localparam int CMD_RX_ON  = 4;
  localparam int CMD_RX_OFF = 5;
  localparam int CMD_TX_ON  = 6;
  localparam int CMD_TX_OFF = 7;
  localparam int CMD_CLRERR = 8;

  // mode fields
  localparam int MODE_PAR_LSB   = 9;
  localparam int MODE_ROUTE_LSB = 14;

  // status bits
  localparam int ST_RX_READY = 0;
  localparam int ST_TX_READY = 1;
  localparam int ST_OVERRUN  = 5;
  localparam int ST_FRAMING  = 6;
  localparam int ST_PARITY   = 7;
  localparam int ST_TX_EMPTY = 9;
  localparam logic [31:0] ST_LEGAL = 32'h0000_02E3;

  typedef enum logic [2:0] {
    PAR_EVEN = 3'd0,
    PAR_ODD  = 3'd1,
    PAR_ZERO = 3'd2,
    PAR_ONE  = 3'd3,
    PAR_OFF  = 3'd4
  } par_e;

  typedef enum logic [1:0] {
    ROUTE_NORMAL = 2'd0,
    ROUTE_ECHO   = 2'd1,
    ROUTE_LOCAL  = 2'd2,
    ROUTE_REMOTE = 2'd3
  } route_e;

  // true when the mode carries a parity bit (codes 5..7 behave as none)
  function automatic logic par_used(input logic [2:0] m);
    return (m < 3'd4);
  endfunction

  // parity bit for a mode, given the XOR of all data bits
  function automatic logic par_bit(input logic [2:0] m, input logic xr);
    case (m)
      PAR_EVEN: return xr;
      PAR_ODD:  return ~xr;
      PAR_ZERO: return 1'b0;
      default:  return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/sp_baud.sv
module sp_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last;

  assign last = div - 1'b1;

  always_ff @(posedge clk) begin
    if (rst || div == '0) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= last) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/sp_tx.sv
module sp_tx import sp_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int OS     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              en,
  input  logic              run,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic [2:0]        par_mode,
  output logic              line,
  output logic              hold_full,
  output logic              busy
);
  localparam int CNT_W = $clog2(OS);
  localparam int IDX_W = $clog2(DATA_W);

  typedef enum logic [2:0] {TS_IDLE, TS_START, TS_DATA, TS_PAR, TS_STOP} tx_state_e;

  tx_state_e         state;
  logic [DATA_W-1:0] hold;
  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic              pbit;
  logic              with_par;
  logic              bit_end;

  assign busy    = (state != TS_IDLE);
  assign bit_end = tick && (cnt == CNT_W'(OS - 1));

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      state     <= TS_IDLE;
      hold      <= '0;
      hold_full <= 1'b0;
      shreg     <= '0;
      cnt       <= '0;
      idx       <= '0;
      pbit      <= 1'b0;
      with_par  <= 1'b0;
      line      <= 1'b1;
    end else begin
      if (load) begin
        hold      <= load_data;
        hold_full <= 1'b1;
      end
      if (!en) begin
        state <= TS_IDLE;
        cnt   <= '0;
        line  <= 1'b1;
      end else begin
        case (state)
          TS_IDLE: begin
            if (hold_full && run) begin
              shreg     <= hold;
              hold_full <= load;
              pbit      <= par_bit(par_mode, ^hold);
              with_par  <= par_used(par_mode);
              cnt       <= '0;
              line      <= 1'b0;
              state     <= TS_START;
            end
          end
          TS_START: begin
            if (tick) cnt <= cnt + 1'b1;
            if (bit_end) begin
              line  <= shreg[0];
              idx   <= '0;
              state <= TS_DATA;
            end
          end
          TS_DATA: begin
            if (tick) cnt <= cnt + 1'b1;
            if (bit_end) begin
              if (idx == IDX_W'(DATA_W - 1)) begin
                line  <= with_par ? pbit : 1'b1;
                state <= with_par ? TS_PAR : TS_STOP;
              end else begin
                shreg <= shreg >> 1;
                line  <= shreg[1];
                idx   <= idx + 1'b1;
              end
            end
          end
          TS_PAR: begin
            if (tick) cnt <= cnt + 1'b1;
            if (bit_end) begin
              line  <= 1'b1;
              state <= TS_STOP;
            end
          end
          TS_STOP: begin
            if (tick) cnt <= cnt + 1'b1;
            if (bit_end) begin
              line  <= 1'b1;
              state <= TS_IDLE;
            end
          end
          default: state <= TS_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sp_rx.sv
module sp_rx import sp_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int OS     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              en,
  input  logic              tick,
  input  logic              line_in,
  input  logic [2:0]        par_mode,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              par_err,
  output logic              frm_err
);
  localparam int CNT_W = $clog2(OS);
  localparam int IDX_W = $clog2(DATA_W);
  localparam int HALF  = OS / 2;

  typedef enum logic [2:0] {RS_IDLE, RS_START, RS_DATA, RS_PAR, RS_STOP} rx_state_e;

  rx_state_e         state;
  logic [1:0]        sync;
  logic              s;
  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic              par_s;
  logic              bit_mid;

  assign s       = sync[1];
  assign bit_mid = (cnt == CNT_W'(OS - 1));

  // two-stage synchronizer on the serial input
  always_ff @(posedge clk) begin
    if (rst) sync <= 2'b11;
    else     sync <= {sync[0], line_in};
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst || !en) begin
      state   <= RS_IDLE;
      cnt     <= '0;
      idx     <= '0;
      done    <= 1'b0;
      par_s   <= 1'b0;
      if (rst) begin
        shreg   <= '0;
        data    <= '0;
        par_err <= 1'b0;
        frm_err <= 1'b0;
      end
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (state)
          RS_IDLE: begin
            if (!s) begin
              cnt   <= '0;
              state <= RS_START;
            end
          end
          RS_START: begin
            if (cnt == CNT_W'(HALF - 1)) begin
              cnt <= '0;
              idx <= '0;
              state <= s ? RS_IDLE : RS_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RS_DATA: begin
            cnt <= cnt + 1'b1;
            if (bit_mid) begin
              shreg <= {s, shreg[DATA_W-1:1]};
              if (idx == IDX_W'(DATA_W - 1))
                state <= par_used(par_mode) ? RS_PAR : RS_STOP;
              else
                idx <= idx + 1'b1;
            end
          end
          RS_PAR: begin
            cnt <= cnt + 1'b1;
            if (bit_mid) begin
              par_s <= s;
              state <= RS_STOP;
            end
          end
          RS_STOP: begin
            cnt <= cnt + 1'b1;
            if (bit_mid) begin
              done    <= 1'b1;
              data    <= shreg;
              frm_err <= !s;
              par_err <= par_used(par_mode) && (par_s != par_bit(par_mode, ^shreg));
              state   <= RS_IDLE;
            end
          end
          default: state <= RS_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/dbg_serial_port.sv
module dbg_serial_port import sp_pkg::*; #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16,
  parameter int OS     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq,
  input  logic              rxd,
  output logic              txd
);
  // decoded strobes
  logic wr_cmd, wr_mode, wr_mset, wr_mclr, wr_txch, wr_baud, rd_rxch;
  assign wr_cmd  = wr_en && (addr == ADDR_W'(OFF_CMD));
  assign wr_mode = wr_en && (addr == ADDR_W'(OFF_MODE));
  assign wr_mset = wr_en && (addr == ADDR_W'(OFF_MSET));
  assign wr_mclr = wr_en && (addr == ADDR_W'(OFF_MCLR));
  assign wr_txch = wr_en && (addr == ADDR_W'(OFF_TXCH));
  assign wr_baud = wr_en && (addr == ADDR_W'(OFF_BAUD));
  assign rd_rxch = rd_en && (addr == ADDR_W'(OFF_RXCH));

  logic rx_rst, tx_rst, clr_err;
  assign rx_rst  = wr_cmd && wdata[CMD_RX_RST];
  assign tx_rst  = wr_cmd && wdata[CMD_TX_RST];
  assign clr_err = wr_cmd && wdata[CMD_CLRERR];

  // configuration state
  logic [2:0]       par_q;
  route_e           route_q;
  logic [31:0]      mask_q;
  logic [DIV_W-1:0] div_q;
  logic             rx_en_q, tx_en_q;

  // receive side state
  logic [DATA_W-1:0] rxch_q;
  logic              rx_ready_q, ovr_q, frm_q, par_q_err;

  // sub-block wires
  logic              tick;
  logic              tx_line, tx_hold_full, tx_busy;
  logic              rx_src;
  logic              rx_done, rx_perr, rx_ferr;
  logic [DATA_W-1:0] rx_data;
  logic              txd_n;
  logic [31:0]       stat_w;

  sp_baud #(.DIV_W(DIV_W)) u_baud (
    .clk  (clk),
    .rst  (rst),
    .div  (div_q),
    .tick (tick)
  );

  sp_tx #(.DATA_W(DATA_W), .OS(OS)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .soft_rst  (tx_rst),
    .en        (tx_en_q),
    .run       (div_q != '0),
    .tick      (tick),
    .load      (wr_txch),
    .load_data (wdata[DATA_W-1:0]),
    .par_mode  (par_q),
    .line      (tx_line),
    .hold_full (tx_hold_full),
    .busy      (tx_busy)
  );

  sp_rx #(.DATA_W(DATA_W), .OS(OS)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (rx_rst),
    .en       (rx_en_q),
    .tick     (tick),
    .line_in  (rx_src),
    .par_mode (par_q),
    .done     (rx_done),
    .data     (rx_data),
    .par_err  (rx_perr),
    .frm_err  (rx_ferr)
  );

  // channel routing
  always_comb begin
    case (route_q)
      ROUTE_NORMAL: begin txd_n = tx_line; rx_src = rxd;     end
      ROUTE_ECHO:   begin txd_n = rxd;     rx_src = rxd;     end
      ROUTE_LOCAL:  begin txd_n = 1'b1;    rx_src = tx_line; end
      default:      begin txd_n = rxd;     rx_src = 1'b1;    end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) txd <= 1'b1;
    else     txd <= txd_n;
  end

  // status word
  always_comb begin
    stat_w              = '0;
    stat_w[ST_RX_READY] = rx_ready_q;
    stat_w[ST_TX_READY] = !tx_hold_full;
    stat_w[ST_OVERRUN]  = ovr_q;
    stat_w[ST_FRAMING]  = frm_q;
    stat_w[ST_PARITY]   = par_q_err;
    stat_w[ST_TX_EMPTY] = !tx_hold_full && !tx_busy;
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      par_q   <= 3'd0;
      route_q <= ROUTE_NORMAL;
      mask_q  <= '0;
      div_q   <= '0;
      rx_en_q <= 1'b0;
      tx_en_q <= 1'b0;
    end else begin
      if (wr_cmd) begin
        if (wdata[CMD_RX_ON])  rx_en_q <= 1'b1;
        if (wdata[CMD_RX_OFF]) rx_en_q <= 1'b0;
        if (wdata[CMD_TX_ON])  tx_en_q <= 1'b1;
        if (wdata[CMD_TX_OFF]) tx_en_q <= 1'b0;
      end
      if (wr_mode) begin
        par_q   <= wdata[MODE_PAR_LSB +: 3];
        route_q <= route_e'(wdata[MODE_ROUTE_LSB +: 2]);
      end
      if (wr_mset) mask_q <= mask_q | (wdata & ST_LEGAL);
      if (wr_mclr) mask_q <= mask_q & ~(wdata & ST_LEGAL);
      if (wr_baud) div_q <= wdata[DIV_W-1:0];
    end
  end

  // receive holding and latched flags
  always_ff @(posedge clk) begin
    if (rst) begin
      rxch_q     <= '0;
      rx_ready_q <= 1'b0;
      ovr_q      <= 1'b0;
      frm_q      <= 1'b0;
      par_q_err  <= 1'b0;
    end else begin
      if (rd_rxch || rx_rst) rx_ready_q <= 1'b0;
      if (clr_err) begin
        ovr_q     <= 1'b0;
        frm_q     <= 1'b0;
        par_q_err <= 1'b0;
      end
      if (rx_done && !rx_rst) begin
        rxch_q     <= rx_data;
        rx_ready_q <= 1'b1;
        if (rx_ready_q && !rd_rxch) ovr_q <= 1'b1;
        if (rx_ferr) frm_q <= 1'b1;
        if (rx_perr) par_q_err <= 1'b1;
      end
    end
  end

  // registered read port and interrupt
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= |(stat_w & mask_q);
      if (rd_en) begin
        case (addr)
          ADDR_W'(OFF_MODE): rdata <= {16'h0, route_q, 2'b00, par_q, 9'h0};
          ADDR_W'(OFF_MASK): rdata <= mask_q;
          ADDR_W'(OFF_STAT): rdata <= stat_w;
          ADDR_W'(OFF_RXCH): rdata <= 32'(rxch_q);
          ADDR_W'(OFF_BAUD): rdata <= 32'(div_q);
          default:           rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/sp_checker.sv
module sp_checker import sp_pkg::*; #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       stat,
  input logic [31:0]       mask,
  input logic [1:0]        route,
  input logic              rx_done,
  input logic              rxd,
  input logic              txd,
  input logic              irq
);
  logic warm;
  always_ff @(posedge clk) warm <= !rst;

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |=> !irq); // R9

  AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFF_MCLR)) |=> ((mask & $past(wdata)) == '0)); // R8

  AST_MASK_SET: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFF_MSET)) |=> ((mask & $past(wdata & ST_LEGAL)) == $past(wdata & ST_LEGAL))); // R8

  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (rst)
    stat[ST_TX_EMPTY] |-> stat[ST_TX_READY]); // R5

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(stat[ST_TX_EMPTY] && route == 2'd0)) |-> txd); // R5

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(OFF_RXCH) && !rx_done) |=> !stat[ST_RX_READY]); // R4

  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFF_CMD) && wdata[CMD_CLRERR] && !rx_done) |=> (stat[7:5] == 3'b000)); // R7

  AST_REMOTE_COPY: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(route == 2'd3)) |-> (txd == $past(rxd))); // R10
endmodule

bind dbg_serial_port sp_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .wdata   (wdata),
  .stat    (stat_w),
  .mask    (mask_q),
  .route   (route_q),
  .rx_done (rx_done),
  .rxd     (rxd),
  .txd     (txd),
  .irq     (irq)
);

// File: tb/dbg_serial_port_test.sv
module dbg_serial_port_test;
  localparam logic [5:0] A_CMD = 6'h00, A_MODE = 6'h04, A_MSET = 6'h08, A_MCLR = 6'h0C,
                         A_MASK = 6'h10, A_STAT = 6'h14, A_RXCH = 6'h18, A_TXCH = 6'h1C,
                         A_BAUD = 6'h20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, txd;
  logic        rxd = 1'b1;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  dbg_serial_port uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .rxd(rxd), .txd(txd)
  );

  function automatic logic exp_par(input logic [2:0] pm, input logic [7:0] b);
    case (pm)
      3'd0: return ^b;
      3'd1: return ~^b;
      3'd2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [31:0] mode_word(input logic [1:0] rt, input logic [2:0] pm);
    return {16'h0, rt, 2'b00, pm, 9'h0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic wait_rx(input string req);
    logic [31:0] d;
    bit ok = 0;
    for (int i = 0; i < 3000 && !ok; i++) begin
      bus_rd(A_STAT, d);
      if (d[0]) ok = 1;
    end
    chk(req, 32'(ok), 32'd1);
  endtask

  task automatic drv_frame(input logic [7:0] b, input logic [2:0] pm, input bit badp,
                           input bit bads, input int bl);
    rxd = 1'b0; repeat (bl) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd = b[i]; repeat (bl) @(negedge clk); end
    if (pm < 3'd4) begin rxd = exp_par(pm, b) ^ badp; repeat (bl) @(negedge clk); end
    if (bads) begin rxd = 1'b0; repeat (bl * 3 / 4) @(negedge clk); end
    rxd = 1'b1; repeat (bl * 2) @(negedge clk);
  endtask

  task automatic cap_tx(input int bl, input bit hp, output logic [7:0] b,
                        output logic p, output logic s);
    int t = 0;
    while (txd !== 1'b0 && t < 20000) begin @(negedge clk); t++; end
    b = 'x; p = 1'b1; s = 1'bx;
    if (t < 20000) begin
      repeat (bl / 2) @(negedge clk);
      for (int i = 0; i < 8; i++) begin repeat (bl) @(negedge clk); b[i] = txd; end
      if (hp) begin repeat (bl) @(negedge clk); p = txd; end
      repeat (bl) @(negedge clk); s = txd;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  b, cb;
    logic        p, s;
    logic [2:0]  pm;
    int          lowlen;

    void'($urandom(32'h51A7));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    bus_rd(A_STAT, d); chk("R1 status", d, 32'h202);
    bus_rd(A_MASK, d); chk("R1 mask", d, 32'h0);
    bus_rd(A_MODE, d); chk("R1 mode", d, 32'h0);
    bus_rd(A_BAUD, d); chk("R1 divisor", d, 32'h0);
    bus_rd(A_RXCH, d); chk("R1 rx char", d, 32'h0);
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 txd", 32'(txd), 32'd1);

    // R2: divisor 0 keeps character waiting
    bus_wr(A_CMD, 32'h50);
    bus_wr(A_TXCH, 32'h3E);
    repeat (300) @(negedge clk);
    chk("R2 div0 txd", 32'(txd), 32'd1);
    bus_rd(A_STAT, d); chk("R2 div0 tx ready", 32'(d[1]), 32'd0);
    bus_wr(A_BAUD, 32'd1);
    cap_tx(16, 1'b1, cb, p, s);
    chk("R2 div0 released char", 32'(cb), 32'h3E);
    repeat (20) @(negedge clk);
    bus_rd(A_STAT, d); chk("R5 empty after frame", 32'(d[9]), 32'd1);

    // R3 R2: transmit waveform in every parity mode
    for (int m = 0; m < 5; m++) begin
      pm = 3'(m);
      b = 8'($urandom);
      bus_wr(A_MODE, mode_word(2'd0, pm));
      bus_wr(A_TXCH, 32'(b));
      cap_tx(16, pm < 3'd4, cb, p, s);
      chk("R2 tx data", 32'(cb), 32'(b));
      if (pm < 3'd4) chk("R3 tx parity bit", 32'(p), 32'(exp_par(pm, b)));
      chk("R2 tx stop", 32'(s), 32'd1);
      repeat (20) @(negedge clk);
    end

    // R4 R3 R10: local loop with random characters and modes
    for (int k = 0; k < 10; k++) begin
      pm = 3'($urandom % 5);
      b = 8'($urandom);
      bus_wr(A_MODE, mode_word(2'd2, pm));
      bus_wr(A_TXCH, 32'(b));
      chk("R10 local txd high", 32'(txd), 32'd1);
      wait_rx("R4 loop ready");
      bus_rd(A_STAT, d); chk("R3 loop no errors", 32'(d[7:5]), 32'd0);
      bus_rd(A_RXCH, d); chk("R4 loop char", d, 32'(b));
      bus_rd(A_STAT, d); chk("R4 read clears ready", 32'(d[0]), 32'd0);
    end

    // R5 R11: disabled transmitter holds the character
    bus_wr(A_MODE, mode_word(2'd0, 3'd4));
    bus_wr(A_CMD, 32'h80);
    bus_wr(A_TXCH, 32'h5A);
    bus_rd(A_STAT, d); chk("R5 ready cleared", 32'(d[1]), 32'd0);
    chk("R5 not empty", 32'(d[9]), 32'd0);
    repeat (300) @(negedge clk);
    chk("R11 disabled tx line high", 32'(txd), 32'd1);
    bus_rd(A_STAT, d); chk("R11 char still held", 32'(d[1]), 32'd0);
    bus_wr(A_CMD, 32'h40);
    repeat (3) @(negedge clk);
    bus_rd(A_STAT, d);
    chk("R5 ready after move", 32'(d[1]), 32'd1);
    chk("R5 busy not empty", 32'(d[9]), 32'd0);
    repeat (200) @(negedge clk);
    bus_rd(A_STAT, d); chk("R5 empty after send", 32'(d[9]), 32'd1);

    // R12: transmitter reset drops waiting character
    bus_wr(A_CMD, 32'h80);
    bus_wr(A_TXCH, 32'hC3);
    bus_wr(A_CMD, 32'h08);
    bus_rd(A_STAT, d); chk("R12 tx reset flags", d & 32'h202, 32'h202);
    bus_wr(A_CMD, 32'h40);
    repeat (200) @(negedge clk);
    chk("R12 dropped char not sent", 32'(txd), 32'd1);

    // R4 R7: bench-driven receive, even parity
    bus_wr(A_MODE, mode_word(2'd0, 3'd0));
    drv_frame(8'hA5, 3'd0, 1'b0, 1'b0, 16);
    wait_rx("R4 rx ready");
    bus_rd(A_STAT, d); chk("R7 good frame no errors", 32'(d[7:5]), 32'd0);
    bus_rd(A_RXCH, d); chk("R4 rx char", d, 32'hA5);

    drv_frame(8'h3C, 3'd0, 1'b1, 1'b0, 16);
    wait_rx("R7 rx ready parity");
    bus_rd(A_STAT, d); chk("R7 parity error", 32'(d[7]), 32'd1);
    bus_rd(A_RXCH, d); chk("R7 char kept", d, 32'h3C);
    bus_wr(A_CMD, 32'h100);
    bus_rd(A_STAT, d); chk("R7 error cleared", 32'(d[7:5]), 32'd0);

    bus_wr(A_MODE, mode_word(2'd0, 3'd3));
    drv_frame(8'h11, 3'd3, 1'b0, 1'b1, 16);
    wait_rx("R7 rx ready framing");
    bus_rd(A_STAT, d); chk("R7 framing error", 32'(d[6]), 32'd1);
    chk("R7 mark parity ok", 32'(d[7]), 32'd0);
    bus_rd(A_RXCH, d);
    bus_wr(A_CMD, 32'h100);

    // R6: overrun
    bus_wr(A_MODE, mode_word(2'd0, 3'd4));
    drv_frame(8'h01, 3'd4, 1'b0, 1'b0, 16);
    wait_rx("R6 first ready");
    bus_rd(A_STAT, d); chk("R6 no overrun yet", 32'(d[5]), 32'd0);
    drv_frame(8'h02, 3'd4, 1'b0, 1'b0, 16);
    bus_rd(A_STAT, d); chk("R6 overrun set", 32'(d[5]), 32'd1);
    bus_rd(A_RXCH, d); chk("R6 newer char kept", d, 32'h02);
    bus_wr(A_CMD, 32'h100);

    // R8 R9: interrupt mask and line
    bus_wr(A_MSET, 32'hFFFF_FFFF);
    bus_rd(A_MASK, d); chk("R8 legal mask bits", d, 32'h2E3);
    bus_wr(A_MCLR, 32'hFFFF_FFFF);
    bus_rd(A_MASK, d); chk("R8 mask cleared", d, 32'h0);
    @(negedge clk); chk("R9 irq masked", 32'(irq), 32'd0);
    bus_wr(A_MSET, 32'h1);
    @(negedge clk); chk("R9 irq no rx ready", 32'(irq), 32'd0);
    drv_frame(8'h77, 3'd4, 1'b0, 1'b0, 16);
    wait_rx("R9 rx ready");
    chk("R9 irq on rx ready", 32'(irq), 32'd1);
    bus_wr(A_MCLR, 32'h1);
    @(negedge clk); chk("R9 irq after clear", 32'(irq), 32'd0);
    bus_wr(A_MSET, 32'h2);
    @(negedge clk); chk("R9 irq on tx ready", 32'(irq), 32'd1);
    bus_wr(A_MCLR, 32'h2);
    bus_rd(A_RXCH, d);

    // R11: disabled receiver
    bus_wr(A_CMD, 32'h20);
    drv_frame(8'h99, 3'd4, 1'b0, 1'b0, 16);
    bus_rd(A_STAT, d); chk("R11 rx disabled no char", 32'(d[0]), 32'd0);
    bus_wr(A_CMD, 32'h30);
    drv_frame(8'h98, 3'd4, 1'b0, 1'b0, 16);
    bus_rd(A_STAT, d); chk("R11 disable wins", 32'(d[0]), 32'd0);
    bus_wr(A_CMD, 32'h10);

    // R12: receiver reset clears ready
    drv_frame(8'h42, 3'd4, 1'b0, 1'b0, 16);
    wait_rx("R12 ready before reset");
    bus_wr(A_CMD, 32'h04);
    bus_rd(A_STAT, d); chk("R12 rx reset clears ready", 32'(d[0]), 32'd0);

    // R10: remote loop
    bus_wr(A_MODE, mode_word(2'd3, 3'd4));
    @(negedge clk); rxd = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 remote low", 32'(txd), 32'd0);
    rxd = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 remote high", 32'(txd), 32'd1);
    drv_frame(8'h24, 3'd4, 1'b0, 1'b0, 16);
    bus_rd(A_STAT, d); chk("R10 remote rx idle", 32'(d[0]), 32'd0);

    // R10: echo
    bus_wr(A_MODE, mode_word(2'd1, 3'd4));
    fork
      drv_frame(8'h96, 3'd4, 1'b0, 1'b0, 16);
      cap_tx(16, 1'b0, cb, p, s);
    join
    chk("R10 echo on txd", 32'(cb), 32'h96);
    wait_rx("R10 echo rx ready");
    bus_rd(A_RXCH, d); chk("R10 echo rx char", d, 32'h96);

    // R2: divisor 3 start bit width and loop
    bus_wr(A_MODE, mode_word(2'd0, 3'd4));
    bus_wr(A_BAUD, 32'd3);
    bus_wr(A_TXCH, 32'h55);
    while (txd !== 1'b0) @(negedge clk);
    lowlen = 0;
    while (txd === 1'b0 && lowlen < 100) begin @(negedge clk); lowlen++; end
    chk("R2 start width in range", 32'(lowlen >= 46 && lowlen <= 48), 32'd1);
    repeat (600) @(negedge clk);
    b = 8'($urandom);
    bus_wr(A_MODE, mode_word(2'd2, 3'd1));
    bus_wr(A_TXCH, 32'(b));
    wait_rx("R2 div3 loop ready");
    bus_rd(A_RXCH, d); chk("R2 div3 loop char", d, 32'(b));

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule